// File: doc/BRIEF.md
# Dual-Gate Subpixel Channel Mapper

This block turns a stream of RGB pixels into a stream of single subpixel writes for a dual-gate panel, where every pixel row is written in two gate phases and each gate line holds a full channel line of 3·TRIPLETS subpixels. Every accepted pixel is split into three beats, one 8-bit component per beat. Each beat carries the index of the output channel it belongs to, counted from 1. The component order inside each channel triplet rotates with the gate phase. In delta colour-filter mode it also rotates with the parity of the pixel row.

The first pixel of a frame, marked by `in_sof`, opens an odd row in its first gate phase. After every TRIPLETS pixels the block moves to the next gate line, and the gate phase toggles. The row parity flips after each second-phase line. A direction input chooses whether channels fill upward from channel 1 or downward from the last channel. A downstream line latch can then store each value at its index and close the line on the last-channel flag.

Top module: `dg_subpixel_mapper`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: An accepted pixel (`in_valid` and `in_ready` at a clock edge) appears as three consecutive output beats. The first beat is registered two edges after acceptance. `in_ready` is low for the two cycles after acceptance, so a continuous input gives one beat per cycle.
- R3: With `cf_stripe`=1, triplet positions 0,1,2 (position = (channel−1) mod 3) carry R,B,G in the first gate phase and G,R,B in the second, on odd and even rows alike.
- R4: With `cf_stripe`=0, odd rows use the same pattern as R3: R,B,G in the first phase and G,R,B in the second.
- R5: With `cf_stripe`=0, even rows carry G,R,B in the first gate phase and B,G,R in the second.
- R6: With `shift_fwd`=1, the k-th pixel (k from 0) of a gate line writes channels 3k+1, 3k+2, 3k+3 in that order.
- R7: With `shift_fwd`=0, the k-th pixel of a gate line writes channels 3T−3k, 3T−3k−1, 3T−3k−2 in that order (T = TRIPLETS). Each channel keeps the colour that its position gives in R3–R5.
- R8: `out_last` is 1 only on the 3T-th beat of a gate line. That beat is channel 3T going forward and channel 1 going in reverse.
- R9: A pixel accepted with `in_sof`=1 starts a new frame, even in the middle of a line. It goes to the first triplet of an odd row in the first gate phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cf_stripe | input | 1 | Colour-filter layout: 1 stripe, 0 delta |
| shift_fwd | input | 1 | Fill direction: 1 from channel 1 upward, 0 from the last channel downward |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Mapper can take a pixel this cycle |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_r | input | DW | Red component |
| in_g | input | DW | Green component |
| in_b | input | DW | Blue component |
| out_valid | output | 1 | Subpixel beat present |
| out_data | output | DW | Subpixel value |
| out_chan | output | CHW | Channel index, 1 to 3·TRIPLETS |
| out_last | output | 1 | Final channel of the gate line |

## Verification
The bench builds the mapper with DW=8 and TRIPLETS=4, so a gate line is 12 channels long. With lines this short, one 16-pixel frame passes through all four combinations of row parity and gate phase. Line-end flags and the phase and parity wraps then occur many times per run. This lets both colour-filter modes and both fill directions be compared beat by beat against a scoreboard. It also makes room for a mid-line frame restart and a timed back-to-back burst.

// File: rtl/dgmap_pkg.sv
package dgmap_pkg;

  typedef enum logic [1:0] {
    COL_R = 2'd0,
    COL_G = 2'd1,
    COL_B = 2'd2
  } colour_e;

  typedef enum logic [1:0] {
    PAT_RBG = 2'd0,
    PAT_GRB = 2'd1,
    PAT_BGR = 2'd2
  } pattern_e;

  // Triplet colour order from filter layout, row parity and gate phase.
  function automatic pattern_e pick_pattern(logic stripe, logic even_row, logic second_phase);
    pattern_e p;
    if (stripe || !even_row) p = second_phase ? PAT_GRB : PAT_RBG;
    else                     p = second_phase ? PAT_BGR : PAT_GRB;
    return p;
  endfunction

  // Colour placed at a triplet position (0..2) by a pattern.
  function automatic colour_e colour_at(pattern_e p, logic [1:0] pos);
    colour_e c;
    c = COL_R;
    case (p)
      PAT_RBG: c = (pos == 2'd0) ? COL_R : (pos == 2'd1) ? COL_B : COL_G;
      PAT_GRB: c = (pos == 2'd0) ? COL_G : (pos == 2'd1) ? COL_R : COL_B;
      PAT_BGR: c = (pos == 2'd0) ? COL_B : (pos == 2'd1) ? COL_G : COL_R;
      default: c = COL_R;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dg_line_tracker.sv
module dg_line_tracker #(
  parameter int TRIPLETS = 400,
  localparam int TW = (TRIPLETS > 1) ? $clog2(TRIPLETS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          advance,
  output logic [TW-1:0] trip_idx,
  output logic          second_phase,
  output logic          even_row,
  output logic          line_end
);

  localparam logic [TW-1:0] LAST_TRIP = TW'(TRIPLETS - 1);

  assign line_end = (trip_idx == LAST_TRIP);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      trip_idx     <= '0;
      second_phase <= 1'b0;
      even_row     <= 1'b0;
    end else if (advance) begin
      if (line_end) begin
        trip_idx     <= '0;
        second_phase <= ~second_phase;
        if (second_phase) even_row <= ~even_row;
      end else begin
        trip_idx <= trip_idx + TW'(1);
      end
    end
  end

endmodule

// File: rtl/dg_channel_index.sv
module dg_channel_index #(
  parameter int TRIPLETS = 400,
  localparam int TW  = (TRIPLETS > 1) ? $clog2(TRIPLETS) : 1,
  localparam int CHW = $clog2(3 * TRIPLETS + 1)
) (
  input  logic           shift_fwd,
  input  logic [TW-1:0]  trip_idx,
  input  logic [1:0]     beat,
  output logic [CHW-1:0] chan,
  output logic [1:0]     pos
);

  localparam logic [CHW-1:0] NCH = CHW'(3 * TRIPLETS);

  logic [CHW-1:0] base;
  logic [CHW-1:0] beat_w;

  always_comb begin
    base   = CHW'(trip_idx) + CHW'(trip_idx) + CHW'(trip_idx);
    beat_w = CHW'(beat);
    if (shift_fwd) begin
      chan = base + beat_w + CHW'(1);
      pos  = beat;
    end else begin
      chan = NCH - base - beat_w;
      pos  = 2'd2 - beat;
    end
  end

endmodule

// File: rtl/dg_colour_router.sv
module dg_colour_router #(
  parameter int DW = 8
) (
  input  logic          stripe,
  input  logic          even_row,
  input  logic          second_phase,
  input  logic [1:0]    pos,
  input  logic [DW-1:0] pix_r,
  input  logic [DW-1:0] pix_g,
  input  logic [DW-1:0] pix_b,
  output logic [DW-1:0] sub
);

  import dgmap_pkg::*;

  logic [DW-1:0] comp [3];
  colour_e       sel;

  assign comp[0] = pix_r;
  assign comp[1] = pix_g;
  assign comp[2] = pix_b;

  always_comb begin
    sel = colour_at(pick_pattern(stripe, even_row, second_phase), pos);
    case (sel)
      COL_R:   sub = comp[0];
      COL_G:   sub = comp[1];
      COL_B:   sub = comp[2];
      default: sub = comp[0];
    endcase
  end

endmodule

// File: rtl/dg_subpixel_mapper.sv
module dg_subpixel_mapper #(
  parameter int DW = 8,
  parameter int TRIPLETS = 400,
  localparam int CHW = $clog2(3 * TRIPLETS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cf_stripe,
  input  logic           shift_fwd,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_sof,
  input  logic [DW-1:0]  in_r,
  input  logic [DW-1:0]  in_g,
  input  logic [DW-1:0]  in_b,
  output logic           out_valid,
  output logic [DW-1:0]  out_data,
  output logic [CHW-1:0] out_chan,
  output logic           out_last
);

  localparam int TW = (TRIPLETS > 1) ? $clog2(TRIPLETS) : 1;

  logic          busy;
  logic [1:0]    beat;
  logic [DW-1:0] hold_r, hold_g, hold_b;
  logic          accept;
  logic          final_beat;

  logic [TW-1:0]  trip_idx;
  logic           second_phase;
  logic           even_row;
  logic           line_end;
  logic [CHW-1:0] chan;
  logic [1:0]     pos;
  logic [DW-1:0]  sub;

  assign final_beat = busy && (beat == 2'd2);
  assign in_ready   = !busy || (beat == 2'd2);
  assign accept     = in_valid && in_ready;

  // Pixel hold register and beat counter.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      beat <= 2'd0;
    end else if (accept) begin
      busy <= 1'b1;
      beat <= 2'd0;
    end else if (busy) begin
      if (beat == 2'd2) busy <= 1'b0;
      else              beat <= beat + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      hold_r <= in_r;
      hold_g <= in_g;
      hold_b <= in_b;
    end
  end

  dg_line_tracker #(.TRIPLETS(TRIPLETS)) tracker_i (
    .clk          (clk),
    .rst          (rst),
    .restart      (accept && in_sof),
    .advance      (final_beat),
    .trip_idx     (trip_idx),
    .second_phase (second_phase),
    .even_row     (even_row),
    .line_end     (line_end)
  );

  dg_channel_index #(.TRIPLETS(TRIPLETS)) index_i (
    .shift_fwd (shift_fwd),
    .trip_idx  (trip_idx),
    .beat      (beat),
    .chan      (chan),
    .pos       (pos)
  );

  dg_colour_router #(.DW(DW)) router_i (
    .stripe       (cf_stripe),
    .even_row     (even_row),
    .second_phase (second_phase),
    .pos          (pos),
    .pix_r        (hold_r),
    .pix_g        (hold_g),
    .pix_b        (hold_b),
    .sub          (sub)
  );

  // Registered output beat.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
    end else begin
      out_valid <= busy;
      out_last  <= final_beat && line_end;
      if (busy) begin
        out_data <= sub;
        out_chan <= chan;
      end
    end
  end

endmodule

// File: rtl/dg_subpixel_mapper_chk.sv
module dg_subpixel_mapper_chk #(
  parameter int TRIPLETS = 400,
  localparam int CHW = $clog2(3 * TRIPLETS + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           shift_fwd,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic [CHW-1:0] out_chan,
  input logic           out_last
);

  localparam logic [CHW-1:0] NCH = CHW'(3 * TRIPLETS);

  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_BEAT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##1 out_valid); // R2

  AST_CHAN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_chan >= CHW'(1)) && (out_chan <= NCH)); // R6

  AST_FWD_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(out_valid) && $past(shift_fwd) && shift_fwd &&
     (($past(out_chan) % CHW'(3)) != '0))
    |-> (out_valid && (out_chan == $past(out_chan) + CHW'(1)))); // R6

  AST_REV_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(out_valid) && !$past(shift_fwd) && !shift_fwd &&
     (($past(out_chan) % CHW'(3)) != CHW'(1)))
    |-> (out_valid && (out_chan == $past(out_chan) - CHW'(1)))); // R7

  AST_LAST_EDGE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> (out_chan == (shift_fwd ? NCH : CHW'(1)))); // R8

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R8

endmodule

bind dg_subpixel_mapper dg_subpixel_mapper_chk #(.TRIPLETS(TRIPLETS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .shift_fwd (shift_fwd),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_chan  (out_chan),
  .out_last  (out_last)
);

// File: tb/dg_subpixel_mapper_tb_top.sv
module dg_subpixel_mapper_tb_top;

  localparam int DW  = 8;
  localparam int T   = 4;
  localparam int NCH = 3 * T;
  localparam int CHW = $clog2(3 * T + 1);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cf_stripe = 1'b1;
  logic           shift_fwd = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic           in_sof = 1'b0;
  logic [DW-1:0]  in_r = '0, in_g = '0, in_b = '0;
  logic           out_valid;
  logic [DW-1:0]  out_data;
  logic [CHW-1:0] out_chan;
  logic           out_last;

  always #4 clk = ~clk;

  dg_subpixel_mapper #(.DW(DW), .TRIPLETS(T)) dut_i (
    .clk(clk), .rst(rst), .cf_stripe(cf_stripe), .shift_fwd(shift_fwd),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan), .out_last(out_last)
  );

  typedef struct {
    int    data;
    int    chan;
    bit    last;
    string dtag;
    string ctag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0, cyc = 0;
  int burst_first = -1, burst_last = -1;
  bit done = 1'b0;
  int m_trip = 0, m_phase = 0, m_even = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // 0 red, 1 green, 2 blue at a triplet position.
  function automatic int colour_of(bit stripe, int even, int ph, int pos);
    string seq;
    byte c;
    if (stripe || even == 0) seq = (ph != 0) ? "GRB" : "RBG";
    else                     seq = (ph != 0) ? "BGR" : "GRB";
    c = seq[pos];
    return (c == "R") ? 0 : (c == "G") ? 1 : 2;
  endfunction

  task automatic send(int r, int g, int b, bit sof);
    int comp[3];
    comp[0] = r; comp[1] = g; comp[2] = b;
    if (sof) begin m_trip = 0; m_phase = 0; m_even = 0; end
    for (int k = 0; k < 3; k++) begin
      exp_t e;
      int pos;
      if (shift_fwd) begin e.chan = 3 * m_trip + k + 1; pos = k; end
      else           begin e.chan = NCH - 3 * m_trip - k; pos = 2 - k; end
      e.data = comp[colour_of(cf_stripe, m_even, m_phase, pos)];
      e.last = (m_trip == T - 1) && (k == 2);
      e.dtag = sof ? "R9" : cf_stripe ? "R3" : (m_even != 0) ? "R5" : "R4";
      e.ctag = sof ? "R9" : shift_fwd ? "R6" : "R7";
      sb.push_back(e);
    end
    m_trip++;
    if (m_trip == T) begin
      m_trip = 0;
      if (m_phase != 0) m_even = 1 - m_even;
      m_phase = 1 - m_phase;
    end
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof;
    in_r = DW'(r); in_g = DW'(g); in_b = DW'(b);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (sb.size() != 0 && guard < 200) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(int npix, int seed);
    for (int i = 0; i < npix; i++)
      send(8'h10 + seed + i, 8'h50 + seed + i, 8'h90 + seed + i, i == 0);
    drain();
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    cyc++;
    if (!rst && out_valid) begin
      if (burst_first < 0) burst_first = cyc;
      burst_last = cyc;
      if (sb.size() == 0) begin
        check(1'b0, "R2", int'(out_chan), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(int'(out_data) == e.data, e.dtag, int'(out_data), e.data);
        check(int'(out_chan) == e.chan, e.ctag, int'(out_chan), e.chan);
        check(out_last == e.last, "R8", int'(out_last), int'(e.last));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", int'(in_ready), 1);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_last == 1'b0, "R1", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", int'(in_ready), 1);

    // Stripe, forward, full frame of four gate lines (R3, R6, R8).
    cf_stripe = 1'b1; shift_fwd = 1'b1;
    frame(4 * T, 0);

    // Delta, forward: both parities and both phases (R4, R5).
    cf_stripe = 1'b0;
    frame(4 * T, 8'h20);

    // Delta, reverse fill (R5, R7).
    shift_fwd = 1'b0;
    frame(4 * T, 8'h40);

    // Stripe, reverse, with idle gaps between pixels (R3, R7).
    cf_stripe = 1'b1;
    for (int i = 0; i < 2 * T; i++) begin
      send(8'h01 + i, 8'h31 + i, 8'h61 + i, i == 0);
      repeat (i % 3) @(negedge clk);
    end
    drain();

    // Mid-line frame restart (R9).
    cf_stripe = 1'b0; shift_fwd = 1'b1;
    send(8'hA0, 8'hB0, 8'hC0, 1'b1);
    send(8'hA1, 8'hB1, 8'hC1, 1'b0);
    send(8'hA2, 8'hB2, 8'hC2, 1'b1);
    send(8'hA3, 8'hB3, 8'hC3, 1'b0);
    drain();

    // Back-to-back burst timing (R2): 8 pixels give 24 beats in 24 cycles.
    burst_first = -1; burst_last = -1;
    frame(8, 8'h60);
    check(burst_last - burst_first == 23, "R2", burst_last - burst_first, 23);

    check(sb.size() == 0, "R2", sb.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual %0d expected %0d", sb.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule